// File: doc/BRIEF.md
# Holdover Frequency History Accumulator

This block sits beside a digital PLL and keeps two smoothed copies of the loop's frequency-offset word while the loop tracks an external reference. A holdover controller uses them later. The short-term history follows recent behaviour with a cutoff picked from four halving settings. The long-term history is a much slower average with a cutoff picked from six halving settings. Both are single-pole low-pass filters of the form `y <= y + ((x - y) >>> k)`. Each accumulator keeps `FRAC_W` guard bits below the input width, and only the upper `IN_W` bits are presented.

The long-term filter does not start at its slow programmed time constant. The first accepted sample is loaded directly. The filter then runs an express phase: it starts at four shifts below the base shift and tightens by one shift after each `EXP_SPAN` accepted samples. When it reaches the programmed shift, a ready flag is raised. A flush pulse discards the long-term history, drops the flag and restarts this sequence. Samples only count while the lock qualifier is high.

Top module: `holdover_history_accum`

## Requirements
- R1: While `rst_n` is low and just after it is released, `lt_hist` and `st_hist` read zero and `lt_ready` reads 0.
- R2: A sample is accepted only in a cycle where both `smp_valid` and `ref_locked` are 1. In any other cycle without a flush, all three outputs keep their values.
- R3: The first accepted sample after reset loads both histories directly. On the long-term side, the first accepted sample after a flush does the same. A loaded history reads back exactly the sample value.
- R4: After loading, each accepted sample updates the short-term accumulator A (IN_W+FRAC_W bits, sample aligned to the top) as A + ((X − A) >>> k), with flooring arithmetic shift and k = ST_BASE_SHIFT + `st_cut_sel`. `st_hist` is A's upper IN_W bits, taken by flooring.
- R5: Once `lt_ready` is 1, the long-term accumulator updates the same way with k = LT_BASE_SHIFT + min(`lt_cut_sel`, 5). Values 6 and 7 of the 3-bit select act as 5.
- R6: After the load, the long-term filter uses k = LT_BASE_SHIFT − 4. After every EXP_SPAN accepted samples, it raises k by one. When the update that completes a span would lift k to the programmed value or beyond, `lt_ready` rises in the next cycle. With a fixed select s, this happens after exactly 1 + EXP_SPAN·(4 + s) accepted samples.
- R7: A `lt_flush` pulse clears `lt_hist` to zero and `lt_ready` to 0 on the next edge and restarts the load and express sequence. `lt_ready` never falls except after a flush.
- R8: When a flush and an accepted sample fall in the same cycle, the flush wins on the long-term side and the sample is not applied there. The short-term history still takes the sample. A flush alone leaves `st_hist` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Frequency-offset sample strobe |
| smp_data | input | IN_W | Signed frequency-offset sample |
| ref_locked | input | 1 | High while the loop is locked to an external reference |
| lt_cut_sel | input | 3 | Long-term cutoff select, 0 (widest) to 5 (narrowest) |
| st_cut_sel | input | 2 | Short-term cutoff select, 0 (widest) to 3 (narrowest) |
| lt_flush | input | 1 | Discard the long-term history and restart it |
| lt_hist | output | IN_W | Long-term history word |
| st_hist | output | IN_W | Short-term history word |
| lt_ready | output | 1 | Long-term history has been built |

## Verification
A flush and an accepted sample can land on the same edge. In that cycle the long-term side must drop the sample while the short-term side takes it. The bench drives this case directly in the middle of a settled run. It also scatters flushes over randomised valid, lock and select traffic. A behavioural model of both filters and the express sequence is compared with every output on every cycle. Directed checks confirm the exact sample count at which the ready flag rises, and that the sample after a flush reloads the long-term history verbatim.

// File: rtl/hh_pkg.sv
package hh_pkg;

   typedef enum logic [1:0] {
      LT_EMPTY   = 2'd0,
      LT_EXPRESS = 2'd1,
      LT_STEADY  = 2'd2
   } lt_phase_t;

   localparam int unsigned LT_SEL_MAX = 5;
   localparam int unsigned EXP_DROP   = 4;

   function automatic logic [2:0] clamp_lt_sel(input logic [2:0] s);
      return (s > 3'(LT_SEL_MAX)) ? 3'(LT_SEL_MAX) : s;
   endfunction

endpackage

// File: rtl/hh_lpf_stage.sv
module hh_lpf_stage #(
   parameter int unsigned ACC_W = 24,
   parameter int unsigned KW    = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    load,
   input  logic                    step,
   input  logic [KW-1:0]           k,
   input  logic signed [ACC_W-1:0] x,
   output logic signed [ACC_W-1:0] y
);

   logic signed [ACC_W:0] diff;
   logic signed [ACC_W:0] delta;
   logic signed [ACC_W:0] nxt;

   always_comb begin
      diff  = $signed({x[ACC_W-1], x}) - $signed({y[ACC_W-1], y});
      delta = diff >>> k;
      nxt   = $signed({y[ACC_W-1], y}) + delta;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y <= '0;
      end else if (clear) begin
         y <= '0;
      end else if (load) begin
         y <= x;
      end else if (step) begin
         y <= nxt[ACC_W-1:0];
      end
   end

endmodule

// File: rtl/hh_express_ctrl.sv
module hh_express_ctrl
   import hh_pkg::*;
#(
   parameter int unsigned KW       = 5,
   parameter int unsigned BASE_K   = 10,
   parameter int unsigned EXP_SPAN = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          accept,
   input  logic [KW-1:0] prog_k,
   output logic          load,
   output logic          step,
   output logic [KW-1:0] k_eff,
   output logic          ready
);

   localparam int unsigned CW      = (EXP_SPAN > 1) ? $clog2(EXP_SPAN) : 1;
   localparam logic [KW-1:0] START_K = KW'(BASE_K - EXP_DROP);
   localparam logic [CW-1:0] LAST_CNT = CW'(EXP_SPAN - 1);

   lt_phase_t     phase;
   logic [KW-1:0] k_cur;
   logic [CW-1:0] cnt;
   logic          take;
   logic          span_done;
   logic          reach;

   assign take      = accept & ~flush;
   assign load      = take & (phase == LT_EMPTY);
   assign step      = take & (phase != LT_EMPTY);
   assign k_eff     = (phase == LT_STEADY) ? prog_k : k_cur;
   assign ready     = (phase == LT_STEADY);
   assign span_done = (cnt == LAST_CNT);
   assign reach     = ({1'b0, k_cur} + (KW+1)'(1)) >= {1'b0, prog_k};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= LT_EMPTY;
         k_cur <= START_K;
         cnt   <= '0;
      end else if (flush) begin
         phase <= LT_EMPTY;
         k_cur <= START_K;
         cnt   <= '0;
      end else if (take) begin
         unique case (phase)
            LT_EMPTY: begin
               phase <= LT_EXPRESS;
               k_cur <= START_K;
               cnt   <= '0;
            end
            LT_EXPRESS: begin
               if (span_done) begin
                  cnt <= '0;
                  if (reach) begin
                     phase <= LT_STEADY;
                  end else begin
                     k_cur <= k_cur + KW'(1);
                  end
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            default: begin
               phase <= LT_STEADY;
            end
         endcase
      end
   end

endmodule

// File: rtl/holdover_history_accum.sv
module holdover_history_accum
   import hh_pkg::*;
#(
   parameter int unsigned IN_W          = 16,
   parameter int unsigned FRAC_W        = 8,
   parameter int unsigned LT_BASE_SHIFT = 10,
   parameter int unsigned ST_BASE_SHIFT = 8,
   parameter int unsigned EXP_SPAN      = 64,
   parameter bit          ST_PRELOAD    = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            smp_valid,
   input  logic [IN_W-1:0] smp_data,
   input  logic            ref_locked,
   input  logic [2:0]      lt_cut_sel,
   input  logic [1:0]      st_cut_sel,
   input  logic            lt_flush,
   output logic [IN_W-1:0] lt_hist,
   output logic [IN_W-1:0] st_hist,
   output logic            lt_ready
);

   localparam int unsigned ACC_W = IN_W + FRAC_W;
   localparam int unsigned KW    = $clog2(ACC_W);

   generate
      if (LT_BASE_SHIFT < EXP_DROP) begin : g_bad_lt_base
         $error("LT_BASE_SHIFT must be at least the express drop of 4");
      end
      if (LT_BASE_SHIFT + LT_SEL_MAX >= ACC_W) begin : g_bad_lt_range
         $error("long-term shift range exceeds accumulator width");
      end
      if (ST_BASE_SHIFT + 3 >= ACC_W) begin : g_bad_st_range
         $error("short-term shift range exceeds accumulator width");
      end
      if (EXP_SPAN < 1) begin : g_bad_span
         $error("EXP_SPAN must be at least 1");
      end
      if (IN_W < 2) begin : g_bad_width
         $error("IN_W must be at least 2");
      end
   endgenerate

   logic                    accept;
   logic signed [ACC_W-1:0] x_acc;
   logic [KW-1:0]           lt_prog_k;
   logic [KW-1:0]           lt_k;
   logic [KW-1:0]           st_k;
   logic                    lt_load;
   logic                    lt_step;
   logic                    st_load;
   logic                    st_step;
   logic signed [ACC_W-1:0] lt_acc;
   logic signed [ACC_W-1:0] st_acc;

   assign accept    = smp_valid & ref_locked;
   assign x_acc     = $signed({smp_data, {FRAC_W{1'b0}}});
   assign lt_prog_k = KW'(LT_BASE_SHIFT) + KW'(clamp_lt_sel(lt_cut_sel));
   assign st_k      = KW'(ST_BASE_SHIFT) + KW'(st_cut_sel);

   generate
      if (ST_PRELOAD) begin : g_st_preload
         logic st_seen;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_seen <= 1'b0;
            end else if (accept) begin
               st_seen <= 1'b1;
            end
         end
         assign st_load = accept & ~st_seen;
         assign st_step = accept & st_seen;
      end else begin : g_st_from_zero
         assign st_load = 1'b0;
         assign st_step = accept;
      end
   endgenerate

   hh_express_ctrl #(
      .KW       (KW),
      .BASE_K   (LT_BASE_SHIFT),
      .EXP_SPAN (EXP_SPAN)
   ) u_lt_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (lt_flush),
      .accept (accept),
      .prog_k (lt_prog_k),
      .load   (lt_load),
      .step   (lt_step),
      .k_eff  (lt_k),
      .ready  (lt_ready)
   );

   hh_lpf_stage #(
      .ACC_W (ACC_W),
      .KW    (KW)
   ) u_lt_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (lt_flush),
      .load  (lt_load),
      .step  (lt_step),
      .k     (lt_k),
      .x     (x_acc),
      .y     (lt_acc)
   );

   hh_lpf_stage #(
      .ACC_W (ACC_W),
      .KW    (KW)
   ) u_st_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (1'b0),
      .load  (st_load),
      .step  (st_step),
      .k     (st_k),
      .x     (x_acc),
      .y     (st_acc)
   );

   assign lt_hist = lt_acc[ACC_W-1:FRAC_W];
   assign st_hist = st_acc[ACC_W-1:FRAC_W];

endmodule

// File: rtl/hh_checker.sv
module hh_checker #(
   parameter int unsigned IN_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            smp_valid,
   input logic            ref_locked,
   input logic            lt_flush,
   input logic [IN_W-1:0] lt_hist,
   input logic [IN_W-1:0] st_hist,
   input logic            lt_ready
);

   assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(smp_valid && ref_locked) && !lt_flush) |=>
         ($stable(lt_hist) && $stable(st_hist) && $stable(lt_ready)));

   assert_ready_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lt_ready) |-> $past(smp_valid && ref_locked && !lt_flush));

   assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lt_flush |=> (!lt_ready && (lt_hist == '0)));

   assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lt_ready) |-> $past(lt_flush));

   assert_flush_spares_st_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lt_flush && !(smp_valid && ref_locked)) |=> $stable(st_hist));

endmodule

bind holdover_history_accum hh_checker #(.IN_W(IN_W)) u_hh_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_valid  (smp_valid),
   .ref_locked (ref_locked),
   .lt_flush   (lt_flush),
   .lt_hist    (lt_hist),
   .st_hist    (st_hist),
   .lt_ready   (lt_ready)
);

// File: tb/holdover_history_accum_test.sv
module holdover_history_accum_test;

   localparam int IN_W = 16;
   localparam int FRAC_W = 8;
   localparam int LTB = 6;
   localparam int STB = 4;
   localparam int SPAN = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            smp_valid = 1'b0;
   logic [IN_W-1:0] smp_data = '0;
   logic            ref_locked = 1'b0;
   logic [2:0]      lt_cut_sel = 3'd0;
   logic [1:0]      st_cut_sel = 2'd0;
   logic            lt_flush = 1'b0;
   logic [IN_W-1:0] lt_hist;
   logic [IN_W-1:0] st_hist;
   logic            lt_ready;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   holdover_history_accum #(
      .IN_W(IN_W), .FRAC_W(FRAC_W), .LT_BASE_SHIFT(LTB),
      .ST_BASE_SHIFT(STB), .EXP_SPAN(SPAN), .ST_PRELOAD(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .ref_locked(ref_locked), .lt_cut_sel(lt_cut_sel), .st_cut_sel(st_cut_sel),
      .lt_flush(lt_flush), .lt_hist(lt_hist), .st_hist(st_hist), .lt_ready(lt_ready)
   );

   // behavioural reference model
   longint m_lt, m_st;
   int     m_phase, m_kcur, m_cnt, m_prog;
   bit     m_ready, m_stl;

   always @(posedge clk or negedge rst_n) begin
      longint x;
      bit acc;
      if (!rst_n) begin
         m_lt = 0; m_st = 0; m_phase = 0; m_kcur = LTB - 4; m_cnt = 0;
         m_ready = 0; m_stl = 0;
      end else begin
         acc = smp_valid && ref_locked;
         x = longint'($signed(smp_data)) * 256;
         m_prog = LTB + ((lt_cut_sel > 3'd5) ? 5 : int'(lt_cut_sel));
         if (acc) begin
            if (!m_stl) begin m_st = x; m_stl = 1; end
            else m_st = m_st + ((x - m_st) >>> (STB + int'(st_cut_sel)));
         end
         if (lt_flush) begin
            m_lt = 0; m_phase = 0; m_kcur = LTB - 4; m_cnt = 0; m_ready = 0;
         end else if (acc) begin
            if (m_phase == 0) begin
               m_lt = x; m_phase = 1; m_kcur = LTB - 4; m_cnt = 0;
            end else if (m_phase == 1) begin
               m_lt = m_lt + ((x - m_lt) >>> m_kcur);
               if (m_cnt == SPAN - 1) begin
                  m_cnt = 0;
                  if (m_kcur + 1 >= m_prog) begin m_phase = 2; m_ready = 1; end
                  else m_kcur = m_kcur + 1;
               end else m_cnt = m_cnt + 1;
            end else begin
               m_lt = m_lt + ((x - m_lt) >>> m_prog);
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         cycles++;
         check(longint'($signed(lt_hist)) == (m_lt >>> FRAC_W), "R5/R6 lt_hist model",
               longint'($signed(lt_hist)), m_lt >>> FRAC_W);
         check(longint'($signed(st_hist)) == (m_st >>> FRAC_W), "R4 st_hist model",
               longint'($signed(st_hist)), m_st >>> FRAC_W);
         check(lt_ready == m_ready, "R6 lt_ready model", lt_ready, m_ready);
      end
   end

   task automatic drive(input bit v, input bit lk, input int d, input bit fl);
      @(negedge clk);
      smp_valid = v; ref_locked = lk; smp_data = IN_W'(d); lt_flush = fl;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #200000;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(lt_hist == '0 && st_hist == '0 && lt_ready == 1'b0, "R1 in reset",
            {lt_hist, st_hist}, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check(lt_hist == '0 && st_hist == '0 && lt_ready == 1'b0, "R1 after release",
            {lt_hist, st_hist}, 0);

      // R2: valid samples without lock are ignored
      for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 3000 + i, 1'b0);
      check(lt_hist == '0 && st_hist == '0, "R2 unlocked ignored", lt_hist, 0);

      // R3: first accepted sample loads both histories
      st_cut_sel = 2'd1; lt_cut_sel = 3'd0;
      drive(1'b1, 1'b1, 1000, 1'b0);
      check($signed(lt_hist) == 1000, "R3 lt load", $signed(lt_hist), 1000);
      check($signed(st_hist) == 1000, "R3 st load", $signed(st_hist), 1000);

      // R6: ready rises after 1 + SPAN*4 accepted samples with select 0
      for (int i = 2; i <= 1 + SPAN * 4 + 3; i++) begin
         drive(1'b1, 1'b1, -2000, 1'b0);
         check(lt_ready == (i >= 1 + SPAN * 4), "R6 ready count", lt_ready, i >= 1 + SPAN * 4);
      end

      // R2: locked but no strobe, outputs hold
      begin
         logic [IN_W-1:0] l0, s0;
         l0 = lt_hist; s0 = st_hist;
         for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, 7777, 1'b0);
         check(lt_hist == l0 && st_hist == s0, "R2 no strobe hold", lt_hist, l0);
      end

      // R5: clamped select 7 acts as 5
      lt_cut_sel = 3'd7; st_cut_sel = 2'd3;
      for (int i = 0; i < 40; i++) drive(1'b1, 1'b1, 5000 - 250 * i, 1'b0);

      // R8: flush and accepted sample in the same cycle
      begin
         logic [IN_W-1:0] s0;
         s0 = st_hist;
         drive(1'b1, 1'b1, 12000, 1'b1);
         check(lt_hist == '0 && !lt_ready, "R8 flush wins lt", lt_hist, 0);
         check(st_hist != s0, "R8 st takes sample", st_hist, s0);
         // R7: flush alone leaves st untouched
         s0 = st_hist;
         drive(1'b0, 1'b1, 0, 1'b1);
         check(st_hist == s0 && lt_hist == '0, "R7 flush alone", st_hist, s0);
         drive(1'b1, 1'b1, -321, 1'b0);
         check($signed(lt_hist) == -321, "R3 reload after flush", $signed(lt_hist), -321);
      end

      // R6: express with select 2 takes 1 + SPAN*6 samples
      lt_cut_sel = 3'd2;
      drive(1'b0, 1'b1, 0, 1'b1);
      for (int i = 1; i <= 1 + SPAN * 6 + 2; i++) begin
         drive(1'b1, 1'b1, 400 + i, 1'b0);
         check(lt_ready == (i >= 1 + SPAN * 6), "R6 ready select 2", lt_ready, i >= 1 + SPAN * 6);
      end

      // randomised traffic, all checked against the model
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         smp_valid  = ($urandom_range(3) != 0);
         ref_locked = ($urandom_range(9) != 0);
         smp_data   = IN_W'($signed(16'($urandom_range(20000))) - 16'sd10000);
         lt_flush   = ($urandom_range(99) < 2);
         if ($urandom_range(49) == 0) lt_cut_sel = 3'($urandom_range(7));
         if ($urandom_range(49) == 0) st_cut_sel = 2'($urandom_range(3));
      end
      @(negedge clk);
      smp_valid = 1'b0; lt_flush = 1'b0;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule